// File: doc/BRIEF.md
# CCD frame sequence controller

This block steps a frame-transfer CCD through one exposure cycle each time it is started. The image area has two gate phases, the storage area has one, and there are two serial output registers. A frame runs in a fixed order. First the overflow drain is pulsed to empty the pixels. Then the sensor integrates for a programmed time. In the summing mode a single line-sum pulse follows. After that the image is shifted into storage, and the stored lines are handed one at a time to an external pixel-rate timer.

All outputs are logic-level enables for the analog drivers. The drain clear and the negative drain pulse are separate outputs. The two image gates and the storage gate each have their own output, and the line request goes to the readout timer.

The readout mode and the integration length are captured when the frame starts. The mode decides three things: whether one or both serial registers are used, how many lines are read, and whether the line-sum step runs. The controller keeps track of which field of an interlaced pair is current and advances it by itself.

Top module: `ccd_frame_seq`

## Requirements
- R1: An accepted start opens the frame with `drain_clr_o` high for exactly CLEAR_TICKS consecutive cycles. No gate output and no `drain_neg_o` is high during that time.
- R2: Integration follows the clear. It lasts exactly `integ_len_i`+1 cycles, during which every gate output and both drain outputs are low.
- R3: In mode 3 (line-sum) a single one-cycle pulse follows integration, before the transfer. It appears on `img_g1_o` alone when `field_o`=0 and on `img_g2_o` alone when `field_o`=1. Modes 0, 1 and 2 have no such pulse.
- R4: The parallel transfer issues P pulses. P is LINES+`field_o` in mode 0 (interlace) and mode 3, and LINES in mode 1 (progressive, one register) and mode 2 (progressive, two registers). Each pulse is one cycle with `img_g1_o`, `img_g2_o` and `stor_g_o` all high, followed by one cycle with all three low.
- R5: `drain_neg_o` is high for the whole transfer, 2·P cycles, and at no other time.
- R6: Readout delivers LINES lines in mode 1 and LINES/2 lines in modes 0, 2 and 3. Each line is a one-cycle `line_req_o` together with a `stor_g_o` pulse, after which the controller waits for `line_done_i`.
- R7: `dual_o` is high during the frame's line requests in mode 2 and low in the other modes.
- R8: `frame_done_o` is high for exactly one cycle, in the cycle after the `line_done_i` of the last line is taken. `busy_o` is low in the cycle after that.
- R9: `start_i` is ignored while `busy_o` is high, and so are changes of `mode_i` and `integ_len_i` after the start. `line_done_i` has no effect unless the controller is waiting for a line.
- R10: `field_o` resets to 0. It toggles at the end of each frame in modes 0 and 3, and otherwise stays unchanged.
- R11: While reset is active, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Frame start request |
| mode_i | input | 2 | 0 interlace, 1 progressive single, 2 progressive dual, 3 line-sum |
| integ_len_i | input | IW | Integration length in ticks, minus one |
| line_done_i | input | 1 | Readout timer finished the current line |
| drain_clr_o | output | 1 | Overflow drain clear pulse enable |
| drain_neg_o | output | 1 | Negative drain pulse enable during transfer |
| img_g1_o | output | 1 | Image gate phase 1 clock enable |
| img_g2_o | output | 1 | Image gate phase 2 clock enable |
| stor_g_o | output | 1 | Storage gate clock enable |
| line_req_o | output | 1 | Line start request to readout timer |
| dual_o | output | 1 | Both serial registers in use |
| field_o | output | 1 | Current field, 0 first, 1 second |
| busy_o | output | 1 | Frame in progress |
| frame_done_o | output | 1 | One-cycle end-of-frame strobe |

## Verification
The bench builds the block with LINES=8, CLEAR_TICKS=3 and IW=8. With these values a full frame takes only a few dozen cycles. That makes it affordable to run every mode in both fields, and to cover both integration-length extremes (0 and 255) along with random lengths. The small line count also lets the bench check the exact pulse and line counts, including the LINES+1 transfer of the second field and the halved readout.

// File: rtl/ccd_frame_seq.sv
module ccd_frame_seq #(
  parameter int LINES       = 500,
  parameter int CLEAR_TICKS = 50,
  parameter int IW          = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [1:0]    mode_i,
  input  logic [IW-1:0] integ_len_i,
  input  logic          line_done_i,
  output logic          drain_clr_o,
  output logic          drain_neg_o,
  output logic          img_g1_o,
  output logic          img_g2_o,
  output logic          stor_g_o,
  output logic          line_req_o,
  output logic          dual_o,
  output logic          field_o,
  output logic          busy_o,
  output logic          frame_done_o
);
  localparam int XW = $clog2(2*LINES + 3);
  localparam int KW = $clog2(CLEAR_TICKS + 1);
  localparam int AW = (XW > KW) ? XW : KW;
  localparam int CW = (AW > IW) ? AW : IW;

  typedef enum logic [2:0] {S_IDLE, S_CLEAR, S_INTEG, S_LSUM, S_XFER, S_RREQ, S_RWAIT, S_DONE} st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [1:0]    mode_q;
  logic [IW-1:0] len_q;
  logic          field_q;

  wire paired   = (mode_q == 2'd0) || (mode_q == 2'd3);
  wire [CW-1:0] xfer_load = CW'(2*LINES - 1) + ((paired && field_q) ? CW'(2) : CW'(0));
  wire [CW-1:0] read_load = (mode_q == 2'd1) ? CW'(LINES - 1) : CW'(LINES/2 - 1);
  wire hi_phase = (st == S_XFER) && cnt[0];
  wire in_lsum  = (st == S_LSUM);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      mode_q  <= '0;
      len_q   <= '0;
      field_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (start_i) begin
          mode_q <= mode_i;
          len_q  <= integ_len_i;
          cnt    <= CW'(CLEAR_TICKS - 1);
          st     <= S_CLEAR;
        end
        S_CLEAR: if (cnt == '0) begin
          cnt <= CW'(len_q);
          st  <= S_INTEG;
        end else cnt <= cnt - 1'b1;
        S_INTEG: if (cnt == '0) begin
          if (mode_q == 2'd3) st <= S_LSUM;
          else begin
            cnt <= xfer_load;
            st  <= S_XFER;
          end
        end else cnt <= cnt - 1'b1;
        S_LSUM: begin
          cnt <= xfer_load;
          st  <= S_XFER;
        end
        S_XFER: if (cnt == '0) begin
          cnt <= read_load;
          st  <= S_RREQ;
        end else cnt <= cnt - 1'b1;
        S_RREQ: st <= S_RWAIT;
        S_RWAIT: if (line_done_i) begin
          if (cnt == '0) st <= S_DONE;
          else begin
            cnt <= cnt - 1'b1;
            st  <= S_RREQ;
          end
        end
        S_DONE: begin
          if (paired) field_q <= ~field_q;
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign drain_clr_o  = (st == S_CLEAR);
  assign drain_neg_o  = (st == S_XFER);
  assign img_g1_o     = hi_phase || (in_lsum && !field_q);
  assign img_g2_o     = hi_phase || (in_lsum && field_q);
  assign stor_g_o     = hi_phase || (st == S_RREQ);
  assign line_req_o   = (st == S_RREQ);
  assign busy_o       = (st != S_IDLE);
  assign dual_o       = busy_o && (mode_q == 2'd2);
  assign frame_done_o = (st == S_DONE);
  assign field_o      = field_q;
endmodule

// File: rtl/ccd_frame_seq_chk.sv
module ccd_frame_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic drain_clr_o,
  input logic drain_neg_o,
  input logic img_g1_o,
  input logic img_g2_o,
  input logic stor_g_o,
  input logic line_req_o,
  input logic field_o,
  input logic busy_o,
  input logic frame_done_o
);
  AST_CLEAR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    drain_clr_o |-> !(img_g1_o || img_g2_o || stor_g_o || drain_neg_o)); // R1
  AST_CLEAR_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> drain_clr_o); // R1
  AST_BOTH_GATES_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    (img_g1_o && img_g2_o) |-> drain_neg_o); // R5
  AST_LINE_REQ_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    line_req_o |-> (stor_g_o && !drain_neg_o)); // R6
  AST_LINE_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    line_req_o |=> !line_req_o); // R6
  AST_DONE_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done_o |=> !busy_o); // R8
  AST_FIELD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !frame_done_o) |=> $stable(field_o)); // R10
endmodule

bind ccd_frame_seq ccd_frame_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .drain_clr_o(drain_clr_o), .drain_neg_o(drain_neg_o),
  .img_g1_o(img_g1_o), .img_g2_o(img_g2_o), .stor_g_o(stor_g_o), .line_req_o(line_req_o),
  .field_o(field_o), .busy_o(busy_o), .frame_done_o(frame_done_o));

// File: tb/sim_ccd_frame_seq.sv
module sim_ccd_frame_seq;
  localparam int LINES = 8, CLR = 3, IW = 8;
  logic clk = 0, rst_n = 0, start_i = 0, line_done_i = 0;
  logic [1:0] mode_i = 0;
  logic [IW-1:0] integ_len_i = 0;
  logic drain_clr_o, drain_neg_o, img_g1_o, img_g2_o, stor_g_o, line_req_o, dual_o, field_o, busy_o, frame_done_o;
  int checks = 0, errors = 0;
  bit ef = 0;

  always #2 clk = ~clk;

  ccd_frame_seq #(.LINES(LINES), .CLEAR_TICKS(CLR), .IW(IW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_pulses(input int m, input bit f);
    return (m == 0 || m == 3) ? LINES + f : LINES;
  endfunction
  function automatic int exp_lines(input int m);
    return (m == 1) ? LINES : LINES / 2;
  endfunction

  task automatic run_frame(input int m, input int len, input bit poke);
    int clr = 0, gap = 0, s1 = 0, s2 = 0, x1 = 0, x2 = 0, xs = 0, neg = 0;
    int reqs = 0, dual = 0, done = 0, cyc = 0, pend = 0, ld_cyc = -5, done_cyc = -1;
    bit act = 0, timeout = 0;
    chk(field_o == ef, "R10 field before frame", field_o, ef);
    @(negedge clk);
    start_i = 1; mode_i = 2'(m); integ_len_i = IW'(len);
    @(negedge clk);
    start_i = 0; mode_i = 2'(m + 1); integ_len_i = IW'(len + 7);
    forever begin
      line_done_i = 0; start_i = 0;
      if (drain_clr_o) clr++;
      else if (!act && !(img_g1_o || img_g2_o || stor_g_o || drain_neg_o) && busy_o) gap++;
      if (img_g1_o || img_g2_o || stor_g_o || drain_neg_o) act = 1;
      if (drain_neg_o) begin
        neg++; x1 += img_g1_o; x2 += img_g2_o; xs += stor_g_o;
      end else if (!stor_g_o) begin
        s1 += img_g1_o; s2 += img_g2_o;
      end
      if (frame_done_o) begin done++; done_cyc = cyc; end
      if (pend > 0) begin
        pend--;
        if (pend == 0) begin line_done_i = 1; ld_cyc = cyc; end
      end
      if (line_req_o) begin
        reqs++; dual += dual_o;
        pend = 1 + int'($urandom % 3);
      end
      if (poke && cyc == CLR + 1) begin start_i = 1; line_done_i = 1; end
      if (!busy_o && done > 0) break;
      if (cyc > 5000) begin timeout = 1; break; end
      cyc++;
      @(negedge clk);
    end
    line_done_i = 0; start_i = 0;
    chk(!timeout, "R8 frame completes (watchdog)", cyc, 0);
    chk(clr == CLR, "R1 clear length", clr, CLR);
    chk(gap == len + 1, "R2 integration length", gap, len + 1);
    chk(s1 == ((m == 3 && !ef) ? 1 : 0), "R3 line-sum gate1", s1, (m == 3 && !ef) ? 1 : 0);
    chk(s2 == ((m == 3 && ef) ? 1 : 0), "R3 line-sum gate2", s2, (m == 3 && ef) ? 1 : 0);
    chk(x1 == exp_pulses(m, ef) && x2 == x1 && xs == x1, "R4 transfer pulses", x1 + 1000 * x2 + 1000000 * xs, exp_pulses(m, ef) * 1001001);
    chk(neg == 2 * exp_pulses(m, ef), "R5 drain negative cycles", neg, 2 * exp_pulses(m, ef));
    chk(reqs == exp_lines(m), "R6 line count", reqs, exp_lines(m));
    chk(dual == ((m == 2) ? reqs : 0), "R7 dual register", dual, (m == 2) ? reqs : 0);
    chk(done == 1 && done_cyc == ld_cyc + 1, "R8 done strobe timing", done_cyc, ld_cyc + 1);
    chk(busy_o == 0, "R8 idle after done", busy_o, 0);
    if (poke) chk(done == 1 && reqs == exp_lines(m), "R9 start/line_done ignored", reqs, exp_lines(m));
    if (m == 0 || m == 3) ef = ~ef;
    chk(field_o == ef, "R10 field after frame", field_o, ef);
    repeat (2) @(negedge clk);
    chk(busy_o == 0, "R9 no restart from ignored start", busy_o, 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk({drain_clr_o, drain_neg_o, img_g1_o, img_g2_o, stor_g_o, line_req_o, dual_o, busy_o, frame_done_o, field_o} == 0,
        "R11 reset outputs", {drain_clr_o, drain_neg_o, img_g1_o, img_g2_o, stor_g_o, line_req_o, dual_o, busy_o, frame_done_o, field_o}, 0);
    rst_n = 1;
    @(negedge clk);
    for (int f = 0; f < 2; f++) begin
      run_frame(0, 2, 0);
      run_frame(3, 0, 0);
    end
    run_frame(1, 255, 0);
    run_frame(2, 0, 1);
    run_frame(0, 4, 1);
    run_frame(3, 5, 1);
    for (int i = 0; i < 8; i++) run_frame(int'($urandom % 4), int'($urandom % 40), i[0]);
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule